// File: doc/BRIEF.md
# Page-Write Load Controller

This block is the write front end of a byte-alterable parallel nonvolatile memory, rebuilt on a synchronous clock. It samples the active-low chip enable, output enable and write enable strobes together with a 15-bit address and an 8-bit data bus. A write is recognised when chip enable and write enable are both low while output enable is high. Bytes that land in the same page are collected in a page buffer, along with a per-byte valid mask.

The page stays open for as long as each new byte load starts within a fixed window of the previous accepted load. Once the window runs out with no load in progress, a timed programming cycle begins and `busy` is raised. When that cycle ends, only the loaded bytes are copied into the storage array, the buffer is cleared and `busy` drops.

A load aimed at a different page than the open one is dropped and sets a sticky error flag. Reads through chip enable and output enable return array bytes one clock later. The storage array holds `STORE_PAGES` pages. A page number selects its slot by its low bits, so page numbers that differ only above those bits share storage.

Top module: `page_write_ctrl`

## Requirements
- R1: A byte load is recognised only in cycles where `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe pattern with `oe_n` low, or with `we_n` never low, loads nothing, never starts programming and leaves the array unchanged.
- R2: The byte address is taken in the first cycle of a load, which is the later of the two strobe falls. Changing `addr` later in the same load has no effect on where the byte goes.
- R3: The byte stored is the `din` value present in the last cycle of the load, which is the cycle before the first of the two strobes rises.
- R4: `addr[14:7]` is the page number and `addr[6:0]` is the byte offset. One page takes from 1 to 128 loads, and every offset of a full page is kept.
- R5: `busy` rises on the (`LOAD_WIN_CYC`+1)-th clock edge after the edge that accepted the latest byte load. If a load is active at that edge, it rises at the first later edge with no load active.
- R6: `busy` stays high for exactly `PROG_CYC` cycles. Loads that start while it is high are ignored: they write nothing, open no page and leave `page_err` unchanged.
- R7: A page has no overall time limit. Loads spaced within the window keep `busy` low however long the sequence runs.
- R8: A load whose page number differs from the open page is dropped and sets `page_err`. `page_err` stays at 1 until reset.
- R9: At the end of programming, only the offsets loaded into the page are written to the array and all other bytes keep their values. The buffer and mask are then empty, so the next page writes only its own bytes.
- R10: With `ce_n`=0 and `oe_n`=0, `dout` shows the array byte at `addr` on the next clock and `dout_vld` is 1. Otherwise both are 0. The array slot is chosen by the low log2(`STORE_PAGES`) bits of the page number together with the offset.
- R11: After reset, `busy`=0 and `page_err`=0, no page is open, and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address: page in [14:7], offset in [6:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, one cycle after the read strobe |
| dout_vld | output | 1 | High when `dout` carries array data |
| busy | output | 1 | Programming cycle in progress |
| page_err | output | 1 | Sticky flag for a dropped load to a different page |

## Verification
The loads are driven in two ways: with write enable falling last and with chip enable falling last. Data changes during each strobe, which separates end-of-load data capture from start-of-load data capture. One load moves its address mid-strobe, which shows that the address is taken at the start. Strobe patterns with output enable low or with write enable held high show whether the write qualifier is decoded correctly. A long train of loads spaced inside the window separates a window that restarts from a fixed page deadline. A full 128-byte page, followed by a one-byte rewrite of the same page, shows whether the valid mask limits the commit. Loads to a different page, and loads during programming, exercise the two drop paths, which must act differently on the error flag.

// File: rtl/pwc_pkg.sv
// Package: shared geometry of the page-write controller.
// Assumes an 8-bit data bus and a page of 2**OFF_W bytes.
package pwc_pkg;
    parameter int ADDR_W     = 15;
    parameter int DATA_W     = 8;
    parameter int OFF_W      = 7;
    parameter int PAGE_W     = ADDR_W - OFF_W;
    parameter int PAGE_BYTES = 1 << OFF_W;

    typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pwc_bus_sampler.sv
// Module: pwc_bus_sampler
// Decodes the write qualifier from the sampled strobes. It marks the first
// and last cycles of each byte load and holds the data seen in the last
// active cycle. Assumes the strobes are already synchronous to clk.
module pwc_bus_sampler #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] din,
    output logic              load_act,
    output logic              load_start,
    output logic              load_end,
    output logic [DATA_W-1:0] load_data
);
    logic act_q;

    // Write qualifier: both enables low with the output disabled.
    always_comb begin
        load_act   = ~ce_n & ~we_n & oe_n;
        load_start = load_act & ~act_q;
        load_end   = ~load_act & act_q;
    end

    // Remember the qualifier from the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= load_act;
    end

    // Track the bus data while a load is active; the final value is the one kept.
    always_ff @(posedge clk) begin
        if (!rst_n)        load_data <= '0;
        else if (load_act) load_data <= din;
    end

    p_end_after_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_end |-> $past(load_act));
endmodule

// File: rtl/pwc_page_buf.sv
// Module: pwc_page_buf
// Holds the open page, its byte buffer and its valid mask. It also runs the
// byte-load window counter and asks for programming when the window has run
// out. Loads to a different page are dropped and flagged. Assumes the
// sequencer keeps busy_i high from the cycle after go until prog_done_i.
module pwc_page_buf #(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 8,
    parameter int OFF_W        = 7,
    parameter int IDX_W        = 3,
    parameter int LOAD_WIN_CYC = 10000,
    localparam int PAGE_W      = ADDR_W - OFF_W,
    localparam int PAGE_BYTES  = 1 << OFF_W,
    localparam int WCNT_W      = $clog2(LOAD_WIN_CYC + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         load_act,
    input  logic                         load_start,
    input  logic                         load_end,
    input  logic [DATA_W-1:0]            load_data,
    input  logic                         busy_i,
    input  logic                         prog_done_i,
    output logic                         go,
    output logic                         page_err,
    output logic [IDX_W-1:0]             commit_idx,
    output logic [PAGE_BYTES*DATA_W-1:0] buf_flat,
    output logic [PAGE_BYTES-1:0]        mask
);
    logic              open_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  slot_q;
    logic              ld_ok_q;
    logic [WCNT_W-1:0] cnt_q;
    logic              err_q;
    logic              same_page;
    logic              accept;
    logic              reject;
    logic              store;

    // Decide whether a starting load joins the page, is dropped, or is ignored.
    always_comb begin
        same_page = (addr[ADDR_W-1:OFF_W] == page_q);
        accept    = load_start & ~busy_i & (~open_q | same_page);
        reject    = load_start & ~busy_i & open_q & ~same_page;
        store     = load_end & ld_ok_q;
        go        = open_q & ~busy_i & ~load_act & ~ld_ok_q &
                    (cnt_q == WCNT_W'(LOAD_WIN_CYC));
    end

    // Page state: open flag, page number and the offset of the pending load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            page_q  <= '0;
            slot_q  <= '0;
            ld_ok_q <= 1'b0;
        end else begin
            if (accept) begin
                open_q  <= 1'b1;
                page_q  <= addr[ADDR_W-1:OFF_W];
                slot_q  <= addr[OFF_W-1:0];
                ld_ok_q <= 1'b1;
            end else if (load_end) begin
                ld_ok_q <= 1'b0;
            end
            if (go) open_q <= 1'b0;
        end
    end

    // Byte-load window: restarts on each accepted load and saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      cnt_q <= '0;
        else if (accept)                                 cnt_q <= '0;
        else if (open_q && cnt_q != WCNT_W'(LOAD_WIN_CYC)) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky page-mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (reject) err_q <= 1'b1;
    end

    // One buffer byte and one valid bit per page offset.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || prog_done_i) begin
                buf_flat[g*DATA_W +: DATA_W] <= '0;
                mask[g]                      <= 1'b0;
            end else if (store && slot_q == OFF_W'(g)) begin
                buf_flat[g*DATA_W +: DATA_W] <= load_data;
                mask[g]                      <= 1'b1;
            end
        end
    end

    assign page_err   = err_q;
    assign commit_idx = page_q[IDX_W-1:0];

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |=> $stable(page_q));
    p_mask_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !prog_done_i) |=> $stable(mask));
    p_clear_after_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done_i |=> (mask == '0));
endmodule

// File: rtl/pwc_prog_seq.sv
// Module: pwc_prog_seq
// Times the internal programming cycle. A go pulse raises busy for exactly
// PROG_CYC cycles, and the final busy cycle gives a done pulse. Assumes go
// arrives only while idle.
module pwc_prog_seq #(
    parameter int PROG_CYC = 300000,
    localparam int PCNT_W  = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    logic              busy_q;
    logic [PCNT_W-1:0] pcnt_q;

    // Final cycle of the programming interval.
    assign done = busy_q & (pcnt_q == PCNT_W'(PROG_CYC - 1));
    assign busy = busy_q;

    // Busy flag and elapsed-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pcnt_q <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            pcnt_q <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
            pcnt_q <= '0;
        end else if (busy_q) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done) |=> busy_q);
    p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);
    p_start_on_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(go));
endmodule

// File: rtl/pwc_array.sv
// Module: pwc_array
// Register-array storage of STORE_PAGES pages, which reset to all ones. A
// commit writes the masked bytes of one page in a single cycle. Reads return
// data one cycle after the read strobe.
module pwc_array #(
    parameter int DATA_W  = 8,
    parameter int OFF_W   = 7,
    parameter int IDX_W   = 3,
    localparam int PAGE_BYTES = 1 << OFF_W,
    localparam int DEPTH      = 1 << (IDX_W + OFF_W)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [IDX_W+OFF_W-1:0]       rd_addr,
    input  logic                         commit,
    input  logic [IDX_W-1:0]             commit_idx,
    input  logic [PAGE_BYTES*DATA_W-1:0] buf_flat,
    input  logic [PAGE_BYTES-1:0]        mask,
    output logic [DATA_W-1:0]            dout,
    output logic                         dout_vld
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Storage: erase to all ones at reset, masked page write on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (mask[j]) mem_q[{commit_idx, OFF_W'(j)}] <= buf_flat[j*DATA_W +: DATA_W];
            end
        end
    end

    // Registered read port; drives zero when not reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout     <= rd_en ? mem_q[rd_addr] : '0;
            dout_vld <= rd_en;
        end
    end

    p_dout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> (dout == '0));
    p_vld_follows_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en) |-> dout_vld);
endmodule

// File: rtl/page_write_ctrl.sv
// Module: page_write_ctrl (top)
// Page-write front end: bus sampling, page collection with a byte-load window,
// timed programming and register-array storage. Timing parameters are in
// clock cycles. STORE_PAGES must be a power of two and at least 2.
module page_write_ctrl #(
    parameter int LOAD_WIN_CYC = 10000,
    parameter int PROG_CYC     = 300000,
    parameter int STORE_PAGES  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [14:0] addr,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    output logic        dout_vld,
    output logic        busy,
    output logic        page_err
);
    import pwc_pkg::*;

    localparam int IDX_W = $clog2(STORE_PAGES);

    logic                         load_act;
    logic                         load_start;
    logic                         load_end;
    logic [DATA_W-1:0]            load_data;
    logic                         go;
    logic                         prog_done;
    logic                         busy_w;
    logic [IDX_W-1:0]             commit_idx;
    logic [PAGE_BYTES*DATA_W-1:0] buf_flat;
    logic [PAGE_BYTES-1:0]        mask;
    logic                         rd_en;

    // Read strobe decode.
    assign rd_en = ~ce_n & ~oe_n;
    assign busy  = busy_w;

    pwc_bus_sampler #(.DATA_W(DATA_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .din(din), .load_act(load_act), .load_start(load_start),
        .load_end(load_end), .load_data(load_data)
    );

    pwc_page_buf #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .LOAD_WIN_CYC(LOAD_WIN_CYC)
    ) u_page (
        .clk(clk), .rst_n(rst_n), .addr(addr), .load_act(load_act),
        .load_start(load_start), .load_end(load_end), .load_data(load_data),
        .busy_i(busy_w), .prog_done_i(prog_done), .go(go), .page_err(page_err),
        .commit_idx(commit_idx), .buf_flat(buf_flat), .mask(mask)
    );

    pwc_prog_seq #(.PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy_w), .done(prog_done)
    );

    pwc_array #(.DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .rd_addr(addr[IDX_W+OFF_W-1:0]), .commit(prog_done),
        .commit_idx(commit_idx), .buf_flat(buf_flat), .mask(mask),
        .dout(dout), .dout_vld(dout_vld)
    );

    p_no_load_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && !prog_done) |=> $stable(mask));
endmodule

// File: tb/page_write_ctrl_bench.sv
// Bench: a behavioural reference model is stepped on every clock and compared
// with the outputs at each falling edge, followed by directed read-back checks.
module page_write_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 20;
    localparam int PROG = 50;
    localparam int SP   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_vld, busy, page_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_write_ctrl #(.LOAD_WIN_CYC(WIN), .PROG_CYC(PROG), .STORE_PAGES(SP)) u_page_write_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld),
        .busy(busy), .page_err(page_err)
    );

    // ---------------- reference model ----------------
    logic [7:0] mmem [int];
    logic [7:0] mbuf [int];
    bit         m_actp, m_open, m_ldok, m_busy, m_err, m_dv;
    int         m_page, m_slot, m_cnt, m_pcnt;
    logic [7:0] m_dlat, m_dout;

    function automatic int midx(input int a);
        return ((a >> 7) % SP) * 128 + (a & 127);
    endfunction

    function automatic logic [7:0] mrd(input int i);
        return mmem.exists(i) ? mmem[i] : 8'hFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mmem.delete(); mbuf.delete();
            m_actp = 0; m_open = 0; m_ldok = 0; m_busy = 0; m_err = 0; m_dv = 0;
            m_page = 0; m_slot = 0; m_cnt = 0; m_pcnt = 0; m_dlat = 0; m_dout = 0;
        end else begin
            automatic bit act = !ce_n && !we_n && oe_n;
            automatic bit st  = act && !m_actp;
            automatic bit en  = !act && m_actp;
            automatic bit pd  = m_busy && (m_pcnt == PROG - 1);
            automatic bit ex  = m_open && !m_busy && !act && !m_ldok && (m_cnt >= WIN);
            automatic bit acc = 0;
            if (!ce_n && !oe_n) begin m_dout = mrd(midx(addr)); m_dv = 1; end
            else begin m_dout = 0; m_dv = 0; end
            if (st && !m_busy) begin
                if (!m_open || int'(addr[14:7]) == m_page) begin
                    acc = 1; m_open = 1; m_page = addr[14:7]; m_slot = addr[6:0];
                    m_cnt = 0; m_ldok = 1;
                end else m_err = 1;
            end
            if (!acc && m_open && m_cnt < WIN) m_cnt++;
            if (en) begin
                if (m_ldok) mbuf[m_slot] = m_dlat;
                m_ldok = 0;
            end
            if (act) m_dlat = din;
            if (ex) begin m_open = 0; m_busy = 1; m_pcnt = 0; end
            else if (pd) begin
                foreach (mbuf[k]) mmem[(m_page % SP) * 128 + k] = mbuf[k];
                mbuf.delete(); m_busy = 0; m_pcnt = 0;
            end else if (m_busy) m_pcnt++;
            m_actp = act;
        end
    end

    task automatic chk(input string tag, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5/R6 busy", busy, m_busy);
            chk("R8 page_err", page_err, m_err);
            chk("R10 dout", dout, m_dout);
            chk("R10 dout_vld", dout_vld, m_dv);
        end
    end

    // ---------------- stimulus ----------------
    // One byte load: ce_first selects which strobe falls first; din is the
    // inverse of d until the last active cycle; alt moves addr mid-load.
    task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit ce_first,
                      input int hold, input bit move, input logic [14:0] alt, input bit oe_low);
        @(negedge clk); addr = a; din = ~d; oe_n = oe_low ? 1'b0 : 1'b1;
        if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
        @(negedge clk);
        if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            if (move) addr = alt;
        end
        din = d;
        @(negedge clk);
        if (ce_first) we_n = 1'b1; else ce_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wb(input logic [14:0] a, input logic [7:0] d);
        wr(a, d, 1'b0, 2, 1'b0, '0, 1'b0);
    endtask

    task automatic rd(input logic [14:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk); chk(tag, dout, e);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic settle();
        repeat (WIN + 5) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 page_err", page_err, 0);
        rd(15'h0000, 8'hFF, "R11 erased");

        // R2/R3: both strobe orders, data changing during the load, address moved
        wr(15'h0105, 8'h5A, 1'b0, 3, 1'b0, '0, 1'b0);
        wr(15'h0107, 8'h3C, 1'b1, 2, 1'b0, '0, 1'b0);
        wr(15'h0110, 8'h77, 1'b0, 3, 1'b1, 15'h0111, 1'b0);
        begin
            int bc = 0;
            while (!busy) @(negedge clk);
            while (busy) begin bc++; @(negedge clk); end
            chk("R6 busy length", bc, PROG);
        end
        @(negedge clk);
        rd(15'h0105, 8'h5A, "R3 we-last load");
        rd(15'h0107, 8'h3C, "R3 ce-last load");
        rd(15'h0110, 8'h77, "R2 start address");
        rd(15'h0111, 8'hFF, "R2 moved address untouched");
        rd(15'h0106, 8'hFF, "R9 unloaded offset");

        // R1: inhibited strobe patterns
        wr(15'h0200, 8'h12, 1'b0, 2, 1'b0, '0, 1'b1);
        @(negedge clk); addr = 15'h0201; din = 8'h34; ce_n = 1'b0;
        repeat (3) @(negedge clk); ce_n = 1'b1;
        repeat (WIN + 5) @(negedge clk);
        chk("R1 no programming", busy, 0);
        rd(15'h0200, 8'hFF, "R1 oe low");
        rd(15'h0201, 8'hFF, "R1 we high");

        // R8: load to another page is dropped and flagged
        wb(15'h0080, 8'h11);
        wb(15'h0180, 8'h22);
        @(negedge clk);
        chk("R8 flag set", page_err, 1);
        settle();
        rd(15'h0080, 8'h11, "R8 open page kept");
        rd(15'h0180, 8'hFF, "R8 dropped byte");
        chk("R8 flag sticky", page_err, 1);

        // R6: loads during programming are ignored
        wb(15'h0300, 8'h44);
        while (!busy) @(negedge clk);
        wb(15'h0301, 8'h55);
        while (busy) @(negedge clk);
        repeat (WIN + 5) @(negedge clk);
        chk("R6 no second program", busy, 0);
        rd(15'h0301, 8'hFF, "R6 ignored load");
        rd(15'h0300, 8'h44, "R6 prior load");

        // R7: long train of loads inside the window
        for (int i = 0; i < 8; i++) begin
            wb(15'h0200 + 15'(i), 8'hA0 + 8'(i));
            repeat (8) @(negedge clk);
            chk("R7 page still open", busy, 0);
        end
        settle();
        rd(15'h0200, 8'hA0, "R7 first byte");
        rd(15'h0207, 8'hA7, "R7 last byte");

        // R4: full page, then R9: single-byte rewrite
        for (int i = 0; i < 128; i++)
            wr(15'h0280 + 15'(i), 8'(i) ^ 8'h5C, i[0], 1, 1'b0, '0, 1'b0);
        settle();
        rd(15'h0280, 8'h5C, "R4 offset 0");
        rd(15'h02C3, 8'h43 ^ 8'h5C, "R4 offset 67");
        rd(15'h02FF, 8'h7F ^ 8'h5C, "R4 offset 127");
        wb(15'h0283, 8'h99);
        settle();
        rd(15'h0283, 8'h99, "R9 rewritten byte");
        rd(15'h0284, 8'h04 ^ 8'h5C, "R9 neighbour kept");
        rd(15'h0683, 8'h99, "R10 page alias");
        finish_run();
    end
endmodule